// File: doc/BRIEF.md
# Register window state unit

This block holds the windowed-register bookkeeping for a multithreaded integer core. Each thread owns a current window pointer and four occupancy counters: free windows available to a save, windows a restore can return to, clean windows, and windows belonging to another address space. A save, restore or flush-windows request enters in the execute stage together with its thread id and reaches writeback one cycle later. There the block checks the counters of that thread. It then either commits the new values or reports one of three window traps: spill, fill or clean-window.

A separate write port loads any single field of any thread directly in writeback. A spill trap, or a direct load of the window pointer, means that the whole window must be exchanged with backing storage. For such a thread the block raises a busy flag for a fixed number of cycles. Trap reports are registered and appear the cycle after the writeback commit. The window pointers of all threads are always visible.

Top module: `win_state_unit`

## Requirements
- R1: Reset sets every window pointer to 0, the free-window counter to NUM_WINDOWS-2 (6), all other counters to 0, clears every busy flag and leaves no trap pending.
- R2: A save (op code 2'b01) whose thread has a nonzero free-window counter and clean-window count different from its restorable count moves the pointer up by one modulo 8, decrements the free-window counter and increments the restorable counter.
- R3: A restore (op code 2'b10) with a nonzero restorable counter moves the pointer down by one modulo 8, increments the free-window counter and decrements the restorable counter.
- R4: A save while the free-window counter is 0 reports a spill trap (kind 2'b01), changes no register and wins over the clean-window condition.
- R5: A save with a nonzero free-window counter and clean-window count equal to the restorable count reports a clean-window trap (kind 2'b11); the pointer still moves up by one and the counters are unchanged.
- R6: A restore while the restorable counter is 0 reports a fill trap (kind 2'b10); the pointer still moves down by one modulo 8 and the counters are unchanged.
- R7: A flush-windows request (op code 2'b11) reports a spill trap when the free-window counter differs from NUM_WINDOWS-2, and otherwise completes with no trap and no change.
- R8: A trap is reported with valid, kind, thread id and a flag that is 1 when the other-space counter is nonzero. The report appears in the cycle after the writeback cycle and lasts one cycle.
- R9: The writeback kill input suppresses both the register update and any trap of the operation in writeback.
- R10: The write port loads the field selected by code 0 pointer, 1 free, 2 restorable, 3 clean, 4 other-space with the given data; codes 5 to 7 change nothing.
- R11: When a live operation and a write target the same thread in the same writeback cycle, the write is discarded.
- R12: A spill trap or an accepted pointer write sets the thread's busy flag for exactly SWAP_CYCLES (4) cycles, starting the cycle after the commit.
- R13: An operation or write on one thread leaves every other thread's pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind_e | input | 2 | Execute-stage operation: 0 none, 1 save, 2 restore, 3 flush-windows |
| op_tid_e | input | 2 | Thread of the execute-stage operation |
| kill_w | input | 1 | Cancels the operation in writeback |
| wr_en_w | input | 1 | Direct field write in writeback |
| wr_tid_w | input | 2 | Thread of the field write |
| wr_field_w | input | 3 | Field code of the write |
| wr_data_w | input | 3 | Value written |
| cwp_o | output | 12 | Window pointer per thread, thread t at bits 3t+2..3t |
| swap_busy_o | output | 4 | Full window exchange in progress, per thread |
| trap_valid_o | output | 1 | Window trap report |
| trap_kind_o | output | 2 | Trap kind: 1 spill, 2 fill, 3 clean-window |
| trap_tid_o | output | 2 | Thread of the reported trap |
| trap_other_o | output | 1 | Other-space counter was nonzero |

## Verification
The main sweep loads every combination of the free, restorable and clean-window counters into one thread in rotation. It then issues a save, a restore and a flush-windows request against that same loaded state. Across the three operations this separates the normal commit from each of the three trap conditions and from the spill-over-clean-window precedence. A directed walk from reset runs saves until the free counter empties, then restores until the restorable counter empties. It tells apart the counter updates that only show through later traps. Separate cases aim a write and an operation at the same thread in the same cycle, kill an operation in writeback, and measure the length of the busy window.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_SAVE    = 2'b01,
        OP_RESTORE = 2'b10,
        OP_FLUSH   = 2'b11
    } win_op_e;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'b00,
        TRAP_SPILL = 2'b01,
        TRAP_FILL  = 2'b10,
        TRAP_CLEAN = 2'b11
    } win_trap_e;

    localparam logic [2:0] FLD_CWP     = 3'd0;
    localparam logic [2:0] FLD_FREE    = 3'd1;
    localparam logic [2:0] FLD_RESTORE = 3'd2;
    localparam logic [2:0] FLD_CLEAN   = 3'd3;
    localparam logic [2:0] FLD_OTHER   = 3'd4;

endpackage

// File: rtl/rwm_op_pipe.sv
module rwm_op_pipe
    import rwm_pkg::*;
#(
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  win_op_e          op_e,
    input  logic [TID_W-1:0] tid_e,
    output win_op_e          op_w,
    output logic [TID_W-1:0] tid_w
);
    typedef struct packed {
        win_op_e          op;
        logic [TID_W-1:0] tid;
    } stage_t;

    stage_t stg_d, stg_q;

    always_comb begin
        stg_d.op  = op_e;
        stg_d.tid = tid_e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '{op: OP_NONE, tid: '0};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign op_w  = stg_q.op;
    assign tid_w = stg_q.tid;
endmodule

// File: rtl/rwm_eval.sv
module rwm_eval
    import rwm_pkg::*;
#(
    parameter int NUM_WINDOWS = 8,
    localparam int PTR_W = $clog2(NUM_WINDOWS)
) (
    input  win_op_e          op,
    input  logic [PTR_W-1:0] cwp,
    input  logic [PTR_W-1:0] free_cnt,
    input  logic [PTR_W-1:0] rest_cnt,
    input  logic [PTR_W-1:0] clean_cnt,
    output win_trap_e        trap,
    output logic             upd,
    output logic [PTR_W-1:0] nxt_cwp,
    output logic [PTR_W-1:0] nxt_free,
    output logic [PTR_W-1:0] nxt_rest
);
    localparam logic [PTR_W-1:0] TOP_WIN  = PTR_W'(NUM_WINDOWS - 1);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(NUM_WINDOWS - 2);

    logic [PTR_W-1:0] cwp_up, cwp_dn;

    always_comb begin
        cwp_up = (cwp == TOP_WIN) ? '0 : cwp + 1'b1;
        cwp_dn = (cwp == '0) ? TOP_WIN : cwp - 1'b1;
    end

    always_comb begin
        trap     = TRAP_NONE;
        upd      = 1'b0;
        nxt_cwp  = cwp;
        nxt_free = free_cnt;
        nxt_rest = rest_cnt;
        unique case (op)
            OP_SAVE: begin
                if (free_cnt == '0) begin
                    trap = TRAP_SPILL;
                end else if (clean_cnt == rest_cnt) begin
                    trap    = TRAP_CLEAN;
                    upd     = 1'b1;
                    nxt_cwp = cwp_up;
                end else begin
                    upd      = 1'b1;
                    nxt_cwp  = cwp_up;
                    nxt_free = free_cnt - 1'b1;
                    nxt_rest = rest_cnt + 1'b1;
                end
            end
            OP_RESTORE: begin
                upd     = 1'b1;
                nxt_cwp = cwp_dn;
                if (rest_cnt == '0) begin
                    trap = TRAP_FILL;
                end else begin
                    nxt_free = free_cnt + 1'b1;
                    nxt_rest = rest_cnt - 1'b1;
                end
            end
            OP_FLUSH: begin
                if (free_cnt != FULL_CNT) trap = TRAP_SPILL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rwm_thread_regs.sv
module rwm_thread_regs
    import rwm_pkg::*;
#(
    parameter int NUM_WINDOWS = 8,
    parameter int SWAP_CYCLES = 4,
    localparam int PTR_W = $clog2(NUM_WINDOWS),
    localparam int CNT_W = $clog2(SWAP_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_commit,
    input  logic [PTR_W-1:0] op_cwp,
    input  logic [PTR_W-1:0] op_free,
    input  logic [PTR_W-1:0] op_rest,
    input  logic             wr_commit,
    input  logic [2:0]       wr_field,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             swap_req,
    output logic [PTR_W-1:0] cwp,
    output logic [PTR_W-1:0] free_cnt,
    output logic [PTR_W-1:0] rest_cnt,
    output logic [PTR_W-1:0] clean_cnt,
    output logic [PTR_W-1:0] other_cnt,
    output logic             busy
);
    typedef struct packed {
        logic [PTR_W-1:0] cwp;
        logic [PTR_W-1:0] free_cnt;
        logic [PTR_W-1:0] rest_cnt;
        logic [PTR_W-1:0] clean_cnt;
        logic [PTR_W-1:0] other_cnt;
        logic [CNT_W-1:0] busy_cnt;
    } thr_state_t;

    thr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_commit) begin
            st_d.cwp      = op_cwp;
            st_d.free_cnt = op_free;
            st_d.rest_cnt = op_rest;
        end else if (wr_commit) begin
            unique case (wr_field)
                FLD_CWP:     st_d.cwp       = wr_data;
                FLD_FREE:    st_d.free_cnt  = wr_data;
                FLD_RESTORE: st_d.rest_cnt  = wr_data;
                FLD_CLEAN:   st_d.clean_cnt = wr_data;
                FLD_OTHER:   st_d.other_cnt = wr_data;
                default: ;
            endcase
        end
        if (swap_req) begin
            st_d.busy_cnt = CNT_W'(SWAP_CYCLES);
        end else if (st_q.busy_cnt != '0) begin
            st_d.busy_cnt = st_q.busy_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.free_cnt <= PTR_W'(NUM_WINDOWS - 2);
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp       = st_q.cwp;
    assign free_cnt  = st_q.free_cnt;
    assign rest_cnt  = st_q.rest_cnt;
    assign clean_cnt = st_q.clean_cnt;
    assign other_cnt = st_q.other_cnt;
    assign busy      = (st_q.busy_cnt != '0);
endmodule

// File: rtl/win_state_unit.sv
module win_state_unit
    import rwm_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_WINDOWS = 8,
    parameter int SWAP_CYCLES = 4,
    localparam int TID_W = $clog2(NUM_THREADS),
    localparam int PTR_W = $clog2(NUM_WINDOWS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               op_kind_e,
    input  logic [TID_W-1:0]         op_tid_e,
    input  logic                     kill_w,
    input  logic                     wr_en_w,
    input  logic [TID_W-1:0]         wr_tid_w,
    input  logic [2:0]               wr_field_w,
    input  logic [PTR_W-1:0]         wr_data_w,
    output logic [NUM_THREADS*PTR_W-1:0] cwp_o,
    output logic [NUM_THREADS-1:0]   swap_busy_o,
    output logic                     trap_valid_o,
    output logic [1:0]               trap_kind_o,
    output logic [TID_W-1:0]         trap_tid_o,
    output logic                     trap_other_o
);
    typedef struct packed {
        logic             valid;
        win_trap_e        kind;
        logic [TID_W-1:0] tid;
        logic             other;
    } trap_rec_t;

    win_op_e          op_w;
    logic [TID_W-1:0] tid_w;
    logic             op_live;

    logic [PTR_W-1:0] cwp_a   [NUM_THREADS];
    logic [PTR_W-1:0] free_a  [NUM_THREADS];
    logic [PTR_W-1:0] rest_a  [NUM_THREADS];
    logic [PTR_W-1:0] clean_a [NUM_THREADS];
    logic [PTR_W-1:0] other_a [NUM_THREADS];

    win_trap_e        ev_trap;
    logic             ev_upd;
    logic [PTR_W-1:0] ev_cwp, ev_free, ev_rest;

    trap_rec_t trap_d, trap_q;

    rwm_op_pipe #(.TID_W(TID_W)) pipe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .op_e  (win_op_e'(op_kind_e)),
        .tid_e (op_tid_e),
        .op_w  (op_w),
        .tid_w (tid_w)
    );

    assign op_live = (op_w != OP_NONE) && !kill_w;

    rwm_eval #(.NUM_WINDOWS(NUM_WINDOWS)) eval_i (
        .op        (op_w),
        .cwp       (cwp_a[tid_w]),
        .free_cnt  (free_a[tid_w]),
        .rest_cnt  (rest_a[tid_w]),
        .clean_cnt (clean_a[tid_w]),
        .trap      (ev_trap),
        .upd       (ev_upd),
        .nxt_cwp   (ev_cwp),
        .nxt_free  (ev_free),
        .nxt_rest  (ev_rest)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic op_hit, wr_ok, spill_hit;

        assign op_hit    = op_live && (tid_w == TID_W'(t));
        assign wr_ok     = wr_en_w && (wr_tid_w == TID_W'(t)) && !op_hit;
        assign spill_hit = op_hit && (ev_trap == TRAP_SPILL);

        rwm_thread_regs #(
            .NUM_WINDOWS (NUM_WINDOWS),
            .SWAP_CYCLES (SWAP_CYCLES)
        ) regs_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_commit (op_hit && ev_upd),
            .op_cwp    (ev_cwp),
            .op_free   (ev_free),
            .op_rest   (ev_rest),
            .wr_commit (wr_ok),
            .wr_field  (wr_field_w),
            .wr_data   (wr_data_w),
            .swap_req  (spill_hit || (wr_ok && (wr_field_w == FLD_CWP))),
            .cwp       (cwp_a[t]),
            .free_cnt  (free_a[t]),
            .rest_cnt  (rest_a[t]),
            .clean_cnt (clean_a[t]),
            .other_cnt (other_a[t]),
            .busy      (swap_busy_o[t])
        );

        assign cwp_o[t*PTR_W +: PTR_W] = cwp_a[t];
    end

    always_comb begin
        trap_d.valid = op_live && (ev_trap != TRAP_NONE);
        trap_d.kind  = ev_trap;
        trap_d.tid   = tid_w;
        trap_d.other = (other_a[tid_w] != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= '{valid: 1'b0, kind: TRAP_NONE, tid: '0, other: 1'b0};
        end else begin
            trap_q <= trap_d;
        end
    end

    assign trap_valid_o = trap_q.valid;
    assign trap_kind_o  = trap_q.kind;
    assign trap_tid_o   = trap_q.tid;
    assign trap_other_o = trap_q.other;
endmodule

// File: rtl/win_state_unit_chk.sv
module win_state_unit_chk #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_WINDOWS = 8,
    localparam int TID_W = $clog2(NUM_THREADS),
    localparam int PTR_W = $clog2(NUM_WINDOWS)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         kill_w,
    input logic [NUM_THREADS*PTR_W-1:0] cwp_o,
    input logic [NUM_THREADS-1:0]       swap_busy_o,
    input logic                         trap_valid_o,
    input logic [1:0]                   trap_kind_o,
    input logic [TID_W-1:0]             trap_tid_o
);
    localparam logic [PTR_W-1:0] TOP_WIN = PTR_W'(NUM_WINDOWS - 1);

    logic [NUM_THREADS*PTR_W-1:0] cwp_prev_q;
    logic [PTR_W-1:0] now_cwp, old_cwp, old_up, old_dn;

    always_ff @(posedge clk) begin
        if (!rst_n) cwp_prev_q <= '0;
        else        cwp_prev_q <= cwp_o;
    end

    assign now_cwp = cwp_o[trap_tid_o*PTR_W +: PTR_W];
    assign old_cwp = cwp_prev_q[trap_tid_o*PTR_W +: PTR_W];
    assign old_up  = (old_cwp == TOP_WIN) ? '0 : old_cwp + 1'b1;
    assign old_dn  = (old_cwp == '0) ? TOP_WIN : old_cwp - 1'b1;

    // R4
    spill_holds_cwp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_o && trap_kind_o == 2'b01) |-> (now_cwp == old_cwp));

    // R5
    clean_moves_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_o && trap_kind_o == 2'b11) |-> (now_cwp == old_up));

    // R6
    fill_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_o && trap_kind_o == 2'b10) |-> (now_cwp == old_dn));

    // R8
    trap_kind_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> (trap_kind_o != 2'b00));

    // R9
    kill_blocks_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_w |=> !trap_valid_o);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_busy
        // R12
        busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(swap_busy_o[t]) |=> swap_busy_o[t]);
    end
endmodule

bind win_state_unit win_state_unit_chk #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_WINDOWS (NUM_WINDOWS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .kill_w       (kill_w),
    .cwp_o        (cwp_o),
    .swap_busy_o  (swap_busy_o),
    .trap_valid_o (trap_valid_o),
    .trap_kind_o  (trap_kind_o),
    .trap_tid_o   (trap_tid_o)
);

// File: tb/win_state_unit_tb_top.sv
module win_state_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_kind_e = 2'b00;
    logic [1:0]  op_tid_e = 2'b00;
    logic        kill_w = 1'b0;
    logic        wr_en_w = 1'b0;
    logic [1:0]  wr_tid_w = 2'b00;
    logic [2:0]  wr_field_w = 3'd0;
    logic [2:0]  wr_data_w = 3'd0;
    logic [11:0] cwp_o;
    logic [3:0]  swap_busy_o;
    logic        trap_valid_o;
    logic [1:0]  trap_kind_o;
    logic [1:0]  trap_tid_o;
    logic        trap_other_o;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_cwp [NT];
    int m_free[NT];
    int m_rest[NT];
    int m_clean[NT];
    int m_other[NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    win_state_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_kind_e(op_kind_e), .op_tid_e(op_tid_e),
        .kill_w(kill_w), .wr_en_w(wr_en_w), .wr_tid_w(wr_tid_w),
        .wr_field_w(wr_field_w), .wr_data_w(wr_data_w), .cwp_o(cwp_o),
        .swap_busy_o(swap_busy_o), .trap_valid_o(trap_valid_o),
        .trap_kind_o(trap_kind_o), .trap_tid_o(trap_tid_o),
        .trap_other_o(trap_other_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cwp_of(input int t);
        return int'(cwp_o[t*3 +: 3]);
    endfunction

    task automatic do_write(input int t, input int f, input int v);
        @(negedge clk);
        wr_en_w = 1'b1; wr_tid_w = 2'(t); wr_field_w = 3'(f); wr_data_w = 3'(v);
        @(negedge clk);
        wr_en_w = 1'b0;
        case (f)
            0: m_cwp[t] = v;
            1: m_free[t] = v;
            2: m_rest[t] = v;
            3: m_clean[t] = v;
            4: m_other[t] = v;
            default: ;
        endcase
    endtask

    // k: 1 save, 2 restore, 3 flush; returns expected trap kind
    function automatic int model_op(input int t, input int k, output int ncwp,
                                    output int nfree, output int nrest);
        int tr = 0;
        ncwp = m_cwp[t]; nfree = m_free[t]; nrest = m_rest[t];
        if (k == 1) begin
            if (m_free[t] == 0) tr = 1;
            else if (m_clean[t] == m_rest[t]) begin tr = 3; ncwp = (m_cwp[t] + 1) % NW; end
            else begin
                ncwp = (m_cwp[t] + 1) % NW; nfree = m_free[t] - 1; nrest = m_rest[t] + 1;
            end
        end else if (k == 2) begin
            ncwp = (m_cwp[t] + NW - 1) % NW;
            if (m_rest[t] == 0) tr = 2;
            else begin nfree = m_free[t] + 1; nrest = m_rest[t] - 1; end
        end else if (k == 3) begin
            if (m_free[t] != NW - 2) tr = 1;
        end
        return tr;
    endfunction

    task automatic do_op(input int t, input int k, input bit kill, input string req);
        int ncwp, nfree, nrest, tr;
        tr = model_op(t, k, ncwp, nfree, nrest);
        @(negedge clk);
        op_kind_e = 2'(k); op_tid_e = 2'(t);
        @(negedge clk);
        op_kind_e = 2'b00; kill_w = kill;
        @(negedge clk);
        kill_w = 1'b0;
        if (kill) begin
            tr = 0; ncwp = m_cwp[t]; nfree = m_free[t]; nrest = m_rest[t];
        end
        chk(req, int'(trap_valid_o), (tr != 0) ? 1 : 0);
        if (tr != 0) begin
            chk({req, " kind"}, int'(trap_kind_o), tr);
            chk({req, " tid R8"}, int'(trap_tid_o), t);
            chk({req, " other R8"}, int'(trap_other_o), (m_other[t] != 0) ? 1 : 0);
        end
        chk({req, " cwp"}, cwp_of(t), ncwp);
        if (tr == 1) chk({req, " busy R12"}, int'(swap_busy_o[t]), 1);
        m_cwp[t] = ncwp; m_free[t] = nfree; m_rest[t] = nrest;
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_cwp[t] = 0; m_free[t] = NW - 2; m_rest[t] = 0; m_clean[t] = 0; m_other[t] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cwp", int'(cwp_o), 0);
        chk("R1 busy", int'(swap_busy_o), 0);
        chk("R1 trap", int'(trap_valid_o), 0);
        do_op(0, 3, 1'b0, "R1 flush at reset free count");
        do_op(0, 1, 1'b0, "R5 first save clean trap");

        // R11 write to same thread as live op is dropped
        @(negedge clk);
        op_kind_e = 2'b01; op_tid_e = 2'd3;
        @(negedge clk);
        op_kind_e = 2'b00;
        wr_en_w = 1'b1; wr_tid_w = 2'd3; wr_field_w = 3'd0; wr_data_w = 3'd5;
        @(negedge clk);
        wr_en_w = 1'b0;
        chk("R11 cwp follows op", cwp_of(3), 1);
        chk("R11 no busy", int'(swap_busy_o[3]), 0);
        chk("R11 clean trap", int'(trap_kind_o), 3);
        m_cwp[3] = 1;

        // R2 R4 R3 R6 R7 walk on thread 1
        do_write(1, 3, 7);
        for (int i = 0; i < 6; i++) do_op(1, 1, 1'b0, "R2 save walk");
        do_op(1, 1, 1'b0, "R4 save on empty free count");
        do_op(1, 3, 1'b0, "R7 flush spill");
        for (int i = 0; i < 6; i++) do_op(1, 2, 1'b0, "R3 restore walk");
        do_op(1, 2, 1'b0, "R6 restore fill");
        do_op(1, 3, 1'b0, "R7 flush quiet");
        chk("R13 thread 0 untouched", cwp_of(0), m_cwp[0]);
        chk("R13 thread 2 untouched", cwp_of(2), 0);

        // R9 kill
        do_write(2, 4, 3);
        do_op(2, 1, 1'b1, "R9 killed save");
        do_op(2, 3, 1'b1, "R9 killed flush");
        do_write(2, 1, 0);
        do_op(2, 1, 1'b1, "R9 killed spill");
        chk("R9 no busy", int'(swap_busy_o[2]), 0);

        // R10 ignored field codes and R12 busy length
        do_write(2, 6, 7);
        do_op(2, 3, 1'b0, "R10 code 6 ignored");
        repeat (6) @(negedge clk);
        do_write(2, 0, 4);
        chk("R10 cwp load", cwp_of(2), 4);
        for (int i = 0; i < 5; i++) begin
            chk("R12 busy window", int'(swap_busy_o[2]), (i < 4) ? 1 : 0);
            @(negedge clk);
        end

        // sweep of all counter combinations, thread rotating
        for (int idx = 0; idx < 512; idx++) begin
            int t = idx % NT;
            for (int k = 1; k <= 3; k++) begin
                do_write(t, 1, idx % 8);
                do_write(t, 2, (idx / 8) % 8);
                do_write(t, 3, idx / 64);
                do_write(t, 4, (idx % 3 == 0) ? 0 : (idx % 8));
                case (k)
                    1: do_op(t, 1, 1'b0, "R2 R4 R5 sweep save");
                    2: do_op(t, 2, 1'b0, "R3 R6 sweep restore");
                    default: do_op(t, 3, 1'b0, "R7 sweep flush");
                endcase
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule